// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock divider from its present ratio to a requested one, chosen from divide-by-1, 2, 4, 6 and 8. It owns two registers and drives them straight out: a 3-bit divider-mode field that the clock generator decodes, and a memory-control word that holds the DRAM refresh count and the self-refresh enable. Because a ratio change alters the DRAM refresh timing, every step updates these registers in a fixed, direction-dependent order.

A request arrives as a target index over a valid/ready handshake. The sequencer splits the change into steps, forcing a detour through divide-by-2 whenever divide-by-1 meets a ratio above 2. For each step it computes the new refresh count from the core clock frequency parameter. After every divider write it waits for the PLL to lock. When the refresh timing slows with self-refresh off, it waits for the outstanding refresh counts to drain. A one-cycle `done` pulse closes the request, with `err` set when the request could not be served.

Top module: `clkdiv_seq`

## Requirements
- R1: The divider-mode field always holds a legal code. Index 0 maps to /1 = 000, index 1 to /2 = 001, index 2 to /4 = 011, index 3 to /6 = 010 and index 4 to /8 = 100.
- R2: A request with an index of 5, 6 or 7 ends with `done` and `err` both high in the same cycle, and no register changes.
- R3: A request whose target equals the current ratio ends with `done` high, `err` low and no register changes.
- R4: The divider never goes directly between /1 and /4, /6 or /8. Such a change is made as two steps with /2 in between.
- R5: Going from /2 to /1, the order is: self-refresh enable cleared, then divider written, then refresh count updated.
- R6: Going from /1 to /2, the order is: refresh count updated, then divider written, then self-refresh enable set.
- R7: Between ratios of 2 or more, a larger divisor gets the refresh count first and the divider second. A smaller divisor gets the divider first and the refresh count second.
- R8: `mem_ctl` is 17 bits wide. Bit 16 is self-refresh enable, bits 14:8 are the refresh count, and all other bits are zero. The count is floor(CORE_HZ × 7.8 µs / (64 × new divisor)).
- R9: After any divider write, at least LOCK_CYC (default 16) cycles pass before the next register change or `done`.
- R10: A refresh update in a /1→/2 step, or in a step to a smaller divisor, is followed by a drain wait when self-refresh is off. The wait is at least 64 × (old count + new count) × old divisor cycles before the next register change or `done`.
- R11: `req_ready` is high only while idle. It drops the cycle after a request is accepted and stays low until `done` pulses. `done` lasts exactly one cycle.
- R12: After reset the ratio is /1, self-refresh is off, the refresh count holds the /1 value, `req_ready` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, ready to accept a request |
| req_index | input | 3 | Target ratio index (0..4 legal) |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | Request rejected; valid while `done` is high |
| div_mode | output | 3 | Divider-mode register |
| mem_ctl | output | 17 | Memory-control register (self-refresh enable and refresh count) |

## Verification
The requests cover every kind of step. Single steps are /1→/2 and /2→/1, growing and shrinking steps among the higher ratios, and the two-step routes /1→/6, /1→/8, /8→/1 and /4→/1. Each kind has its own write order, so a swapped order or a missing detour through /2 shows up as a wrong value at a given position in the expected stream. Minimum gaps between events separate the PLL lock wait from the longer drain wait, which only /1→/2 incurs with self-refresh off. Same-ratio and out-of-range requests must yield `done` with no register movement, and they differ only in `err`.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PLAN, S_EXEC, S_WAIT} seq_state_e;
  typedef enum logic [1:0] {K_DN21, K_UP12, K_GROW, K_SHRK} hop_kind_e;
  typedef enum logic [2:0] {OP_SRCLR, OP_SRSET, OP_REFR, OP_WDIV, OP_END} step_op_e;

  localparam int N_RATIOS = 5;
  localparam int CNT_W    = 7;
  localparam int CNT_LSB  = 8;
  localparam int SR_BIT   = 16;
  localparam int MC_W     = 17;

  // divide ratio for a target index (0..4); zero for illegal indices
  function automatic logic [3:0] ratio_of(input logic [2:0] idx);
    case (idx)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // refresh count: floor(hz * 7.8us / (64 * ratio)), saturated to field width
  function automatic logic [CNT_W-1:0] refr_count(input longint hz, input logic [2:0] idx);
    longint ticks;
    longint r;
    r = longint'(ratio_of(idx));
    if (r == 0) r = 1;
    ticks = (hz * 78) / 10_000_000;
    ticks = ticks / (64 * r);
    if (ticks > 127) ticks = 127;
    return CNT_W'(ticks);
  endfunction

  // ordered register operations for each kind of single step
  function automatic step_op_e op_at(input hop_kind_e k, input logic [1:0] s);
    step_op_e o;
    o = OP_END;
    case (k)
      K_DN21: case (s)
        2'd0: o = OP_SRCLR;
        2'd1: o = OP_WDIV;
        2'd2: o = OP_REFR;
        default: o = OP_END;
      endcase
      K_UP12: case (s)
        2'd0: o = OP_REFR;
        2'd1: o = OP_WDIV;
        2'd2: o = OP_SRSET;
        default: o = OP_END;
      endcase
      K_GROW: case (s)
        2'd0: o = OP_REFR;
        2'd1: o = OP_WDIV;
        default: o = OP_END;
      endcase
      default: case (s)
        2'd0: o = OP_WDIV;
        2'd1: o = OP_REFR;
        default: o = OP_END;
      endcase
    endcase
    return o;
  endfunction

endpackage

// File: rtl/clkdiv_codec.sv
module clkdiv_codec (
  input  logic [2:0] idx_in,
  output logic [2:0] mode_out,
  output logic       idx_ok,
  input  logic [2:0] mode_in,
  output logic [2:0] idx_out,
  output logic       mode_ok
);

  always_comb begin
    idx_ok = 1'b1;
    case (idx_in)
      3'd0:    mode_out = 3'b000;
      3'd1:    mode_out = 3'b001;
      3'd2:    mode_out = 3'b011;
      3'd3:    mode_out = 3'b010;
      3'd4:    mode_out = 3'b100;
      default: begin
        mode_out = 3'b000;
        idx_ok   = 1'b0;
      end
    endcase
  end

  always_comb begin
    mode_ok = 1'b1;
    case (mode_in)
      3'b000:  idx_out = 3'd0;
      3'b001:  idx_out = 3'd1;
      3'b011:  idx_out = 3'd2;
      3'b010:  idx_out = 3'd3;
      3'b100:  idx_out = 3'd4;
      default: begin
        idx_out = 3'd0;
        mode_ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/clkdiv_refr_tbl.sv
module clkdiv_refr_tbl
  import clkdiv_pkg::*;
#(
  parameter longint CORE_HZ = 100_000_000
) (
  input  logic [2:0]       idx,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] tbl [N_RATIOS];

  for (genvar i = 0; i < N_RATIOS; i++) begin : g_entry
    localparam logic [CNT_W-1:0] ENTRY = refr_count(CORE_HZ, 3'(i));
    assign tbl[i] = ENTRY;
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N_RATIOS; i++) begin
      if (idx == 3'(i)) cnt = tbl[i];
    end
  end

endmodule

// File: rtl/clkdiv_timer.sv
module clkdiv_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? '0 : load_val - W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter longint CORE_HZ  = 100_000_000,
  parameter int     LOCK_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_index,
  output logic            done,
  output logic            err,
  output logic [2:0]      div_mode,
  output logic [MC_W-1:0] mem_ctl
);

  localparam int WAIT_W = 18;
  localparam int GAP_W  = $clog2(LOCK_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_RST = refr_count(CORE_HZ, 3'd0);

  seq_state_e       state_q;
  hop_kind_e        kind_q, kind_d;
  logic [2:0]       tgt_q, old_q, hop_q, hop_d, hopmode_q, hop_mode;
  logic [1:0]       step_q;
  logic [2:0]       mode_q;
  logic             sr_q;
  logic [CNT_W-1:0] cnt_q, cnt_new;
  logic             ready_q, done_q, err_q;
  logic [2:0]       cur_idx;
  logic             cur_ok, hop_ok;
  step_op_e         op_now;
  logic             drain_en;
  logic             tmr_load, tmr_expired;
  logic [WAIT_W-1:0] tmr_val, sum_w, drain_len;

  clkdiv_codec u_codec (
    .idx_in   (hop_d),
    .mode_out (hop_mode),
    .idx_ok   (hop_ok),
    .mode_in  (mode_q),
    .idx_out  (cur_idx),
    .mode_ok  (cur_ok)
  );

  clkdiv_refr_tbl #(.CORE_HZ(CORE_HZ)) u_tbl (
    .idx (hop_q),
    .cnt (cnt_new)
  );

  clkdiv_timer #(.W(WAIT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // step planning: detour through /2 when /1 meets a ratio above 2
  always_comb begin
    if ((cur_idx == 3'd0 && tgt_q > 3'd1 && tgt_q < 3'd5) ||
        (cur_idx > 3'd1 && tgt_q == 3'd0))
      hop_d = 3'd1;
    else
      hop_d = tgt_q;

    if (cur_idx == 3'd1 && hop_d == 3'd0)      kind_d = K_DN21;
    else if (cur_idx == 3'd0 && hop_d == 3'd1) kind_d = K_UP12;
    else if (hop_d > cur_idx)                  kind_d = K_GROW;
    else                                       kind_d = K_SHRK;
  end

  // wait lengths
  always_comb begin
    op_now    = op_at(kind_q, step_q);
    drain_en  = (kind_q == K_UP12 || kind_q == K_SHRK) && !sr_q;
    sum_w     = WAIT_W'(cnt_q) + WAIT_W'(cnt_new);
    drain_len = (sum_w * WAIT_W'(ratio_of(old_q))) << 6;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    if (state_q == S_EXEC) begin
      if (op_now == OP_WDIV) begin
        tmr_load = 1'b1;
        tmr_val  = WAIT_W'(LOCK_CYC);
      end else if (op_now == OP_REFR && drain_en) begin
        tmr_load = 1'b1;
        tmr_val  = drain_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      kind_q    <= K_GROW;
      tgt_q     <= '0;
      old_q     <= '0;
      hop_q     <= '0;
      hopmode_q <= '0;
      step_q    <= '0;
      mode_q    <= 3'b000;
      sr_q      <= 1'b0;
      cnt_q     <= CNT_RST;
      ready_q   <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid && ready_q) begin
            tgt_q   <= req_index;
            ready_q <= 1'b0;
            state_q <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (!hop_ok || !cur_ok) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ready_q <= 1'b1;
            state_q <= S_IDLE;
          end else if (cur_idx == tgt_q) begin
            done_q  <= 1'b1;
            ready_q <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            old_q     <= cur_idx;
            hop_q     <= hop_d;
            hopmode_q <= hop_mode;
            kind_q    <= kind_d;
            step_q    <= '0;
            state_q   <= S_EXEC;
          end
        end
        S_EXEC: begin
          step_q <= step_q + 2'd1;
          case (op_now)
            OP_SRCLR: sr_q <= 1'b0;
            OP_SRSET: sr_q <= 1'b1;
            OP_REFR: begin
              cnt_q <= cnt_new;
              if (drain_en) state_q <= S_WAIT;
            end
            OP_WDIV: begin
              mode_q  <= hopmode_q;
              state_q <= S_WAIT;
            end
            default: state_q <= S_PLAN;
          endcase
        end
        default: begin
          if (tmr_expired) state_q <= S_EXEC;
        end
      endcase
    end
  end

  assign req_ready = ready_q;
  assign done      = done_q;
  assign err       = err_q;
  assign div_mode  = mode_q;

  always_comb begin
    mem_ctl                          = '0;
    mem_ctl[SR_BIT]                  = sr_q;
    mem_ctl[CNT_LSB +: CNT_W]        = cnt_q;
  end

  // cycles since the last divider change, saturating
  logic [2:0]       mode_dly;
  logic [GAP_W-1:0] since_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_dly  <= 3'b000;
      since_div <= GAP_W'(LOCK_CYC);
    end else begin
      mode_dly <= mode_q;
      if (mode_q != mode_dly)
        since_div <= '0;
      else if (since_div < GAP_W'(LOCK_CYC))
        since_div <= since_div + GAP_W'(1);
    end
  end

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst) cur_ok);

  a_r4_leave_div1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == 3'b000 && mode_q != 3'b000) |-> mode_q == 3'b001);

  a_r4_enter_div1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) != 3'b000 && mode_q == 3'b000) |-> $past(mode_q) == 3'b001);

  a_r5_srclr_at_div2: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_q) |-> mode_q == 3'b001);

  a_r6_srset_at_div2: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_q) |-> mode_q == 3'b001);

  a_r9_lock_gap: assert property (@(posedge clk) disable iff (rst)
    (mem_ctl != $past(mem_ctl) || done_q) |-> since_div >= GAP_W'(LOCK_CYC));

  a_r11_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

endmodule

// File: tb/test_clkdiv_seq.sv
module test_clkdiv_seq;

  localparam longint CORE_HZ  = 100_000_000;
  localparam int     LOCK_CYC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_index = '0;
  logic        done, err;
  logic [2:0]  div_mode;
  logic [16:0] mem_ctl;

  clkdiv_seq #(.CORE_HZ(CORE_HZ), .LOCK_CYC(LOCK_CYC)) i_clkdiv_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .done(done), .err(err),
    .div_mode(div_mode), .mem_ctl(mem_ctl)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          kind;   // 0 divider, 1 mem_ctl, 2 done (val = err)
    logic [16:0] val;
    int          mingap;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  int   m_idx = 0;
  bit   m_sr  = 0;
  int   m_cnt;

  function automatic logic [2:0] mode_of(int idx);
    case (idx)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic int div_of(int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int cnt_of(int idx);
    longint t;
    t = (CORE_HZ * 78) / 10_000_000;
    t = t / (64 * div_of(idx));
    return int'(t);
  endfunction

  function automatic logic [16:0] mem_val(bit sr, int c);
    logic [16:0] v;
    v = '0;
    v[16] = sr;
    v[14:8] = 7'(c);
    return v;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int kind, logic [16:0] val, int gap, string tag);
    item_t it;
    it.kind = kind; it.val = val; it.mingap = gap; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  logic [2:0]  prev_div;
  logic [16:0] prev_mem;
  int gap = 0;

  task automatic handle(int kind, logic [16:0] val);
    item_t it;
    if (sb.size() == 0) begin
      check(0, "R2/R3", "unexpected event kind", kind, -1);
    end else begin
      it = sb.pop_front();
      check(it.kind == kind, it.tag, "event kind", kind, it.kind);
      check(it.val == val, it.tag, "event value", int'(val), int'(it.val));
      check(gap >= it.mingap, it.tag, "min gap (R9/R10)", gap, it.mingap);
    end
    gap = 0;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      prev_div = div_mode;
      prev_mem = mem_ctl;
      gap = 0;
    end else begin
      gap++;
      if (div_mode != prev_div) handle(0, {14'b0, div_mode});
      if (mem_ctl != prev_mem)  handle(1, mem_ctl);
      if (done)                 handle(2, {16'b0, err});
      prev_div = div_mode;
      prev_mem = mem_ctl;
    end
  end

  // driver: build expected stream from the requirements, then issue request
  task automatic do_req(int idx);
    int g = 1;
    string t;
    if (idx > 4) begin
      push(2, 17'd1, 1, "R2");
    end else if (idx == m_idx) begin
      push(2, 17'd0, 1, "R3");
    end else begin
      while (m_idx != idx) begin
        int h, oc, nc, od;
        h = ((m_idx == 0 && idx > 1) || (m_idx > 1 && idx == 0)) ? 1 : idx;
        t = (h != idx) ? "R4" : "R7";
        od = div_of(m_idx);
        oc = m_cnt;
        nc = cnt_of(h);
        if (m_idx == 1 && h == 0) begin
          m_sr = 0;           push(1, mem_val(m_sr, m_cnt), g, "R5");
                              push(0, {14'b0, mode_of(h)}, 1, "R5 R1");
          m_cnt = nc;         push(1, mem_val(m_sr, m_cnt), LOCK_CYC, "R5 R8");
          g = 1;
        end else if (m_idx == 0 && h == 1) begin
          m_cnt = nc;         push(1, mem_val(m_sr, m_cnt), g, "R6 R8");
          g = m_sr ? 1 : 64 * (oc + nc) * od;
                              push(0, {14'b0, mode_of(h)}, g, "R6 R10");
          m_sr = 1;           push(1, mem_val(m_sr, m_cnt), LOCK_CYC, "R6");
          g = 1;
        end else if (h > m_idx) begin
          m_cnt = nc;         push(1, mem_val(m_sr, m_cnt), g, {t, " R8"});
                              push(0, {14'b0, mode_of(h)}, 1, {t, " R1"});
          g = LOCK_CYC;
        end else begin
                              push(0, {14'b0, mode_of(h)}, g, {t, " R1"});
          m_cnt = nc;         push(1, mem_val(m_sr, m_cnt), LOCK_CYC, {t, " R8"});
          g = m_sr ? 1 : 64 * (oc + nc) * od;
        end
        m_idx = h;
      end
      push(2, 17'd0, g, "R9 R10");
    end

    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_index = 3'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R11", "done single pulse", done, 0);
    check(sb.size() == 0, "R4", "expected events left over", sb.size(), 0);
  endtask

  initial begin
    m_cnt = cnt_of(0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(div_mode == 3'b000, "R12", "reset divider", div_mode, 0);
    check(mem_ctl == mem_val(0, cnt_of(0)), "R12", "reset mem_ctl", mem_ctl, mem_val(0, cnt_of(0)));
    check(req_ready == 1'b1, "R12", "reset ready", req_ready, 1);
    check(done == 1'b0 && err == 1'b0, "R12", "reset done/err", {done, err}, 0);

    do_req(0);   // R3 no-op at /1
    do_req(1);   // R6 /1->/2 with drain (R10)
    do_req(0);   // R5 /2->/1
    do_req(3);   // R4 /1->/2->/6
    do_req(2);   // R7 shrink /6->/4
    do_req(4);   // R7 grow /4->/8
    do_req(5);   // R2 illegal index
    do_req(4);   // R3 no-op at /8
    do_req(0);   // R4 /8->/2->/1
    do_req(7);   // R2 illegal index
    do_req(4);   // R4 /1->/2->/8
    do_req(1);   // R7 shrink /8->/2
    do_req(2);   // R7 grow /2->/4
    do_req(0);   // R4 /4->/2->/1

    repeat (5) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule